// File: doc/BRIEF.md
# Log-Domain Sine Gain Stage

This block produces a signed 8-bit sample equal to a 6-bit gain times the sine of an 8-bit phase. It uses no multiplier. The phase is folded onto a quarter cycle. The logarithm of the sine magnitude and the logarithm of the gain are read from tables and added. An exponential table turns that sum back into a linear magnitude, and the half-cycle bit of the phase sets the sign.

A second instance of the same path can produce a phase-modulated output. A message sine, scaled by its own gain, is added to the carrier phase before the carrier lookup. A full-scale message sample of 127 moves the carrier by almost half a cycle (π). This gives sin(π·m + carrier phase), where m is the message gain times the sine of the message phase.

The block accepts one input set per cycle. Every result appears a fixed number of cycles later and is marked by a valid strobe. Phase accumulation and digital-to-analog conversion are done by neighbouring blocks.

Top module: `log_sine_gain`

## Requirements
- R1: With `pm_en_i`=0, `sample_o` is within 3 LSB of (g/63)·127·sin(2π·p/256), where p is `car_phase_i` and g is `car_gain_i`.
- R2: Gain code 63 is unity. Phase 64 gives exactly +127 and phase 192 gives exactly −127. A valid `sample_o` is never −128.
- R3: Gain code 0 gives a sample of exactly 0 at any phase.
- R4: Phases 0 and 128 give a sample of exactly 0 at any gain.
- R5: Quarter-wave symmetry holds exactly. The sample at p equals the sample at 128−p, and the sample at p+128 is the negation of the sample at p, for p in 1..63.
- R6: With `pm_en_i`=0, phases 0..127 give a sample ≥ 0 and phases 128..255 give a sample ≤ 0.
- R7: With `pm_en_i`=1, `sample_o` is within 12 LSB of (g/63)·127·sin(2π·p/256 + π·(mg/63)·sin(2π·mp/256)), where mp is `msg_phase_i` and mg is `msg_gain_i`. The message sample is added to the carrier phase modulo 256.
- R8: `valid_o` is high exactly 5 cycles after `valid_i` was high. One input set is accepted every cycle, and results come out in input order.
- R9: While `rst_ni` is low, `valid_o` is 0 and `sample_o` is 0.
- R10: With `pm_en_i`=1 and `msg_gain_i`=0, the sample equals the one produced with `pm_en_i`=0 for the same carrier phase and gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input set is valid this cycle |
| pm_en_i | input | 1 | 1: phase-modulated output, 0: plain sine |
| car_phase_i | input | 8 | Carrier phase, 256 steps per cycle |
| car_gain_i | input | 6 | Carrier gain, 63 = unity |
| msg_phase_i | input | 8 | Message phase, 256 steps per cycle |
| msg_gain_i | input | 6 | Message gain, 63 = full modulation depth |
| valid_o | output | 1 | Sample is valid this cycle |
| sample_o | output | 8 | Signed two's-complement sample |

## Verification
The assertions check, on every cycle, the properties that hold for every input:
- the fixed delay from input strobe to output strobe;
- zero output for zero gain and at the two zero crossings;
- the sign of each half-cycle in plain-sine mode;
- the absence of −128.

How close the output is to the real-valued product, the exact mirror symmetry between quarters, the peak values, and the effect of the message on the carrier phase depend on particular pairs or sets of inputs. Only the bench's directed and tabulated scenarios can show these.

// File: rtl/lgs_pkg.sv
package lgs_pkg;
  localparam int  PH_W      = 8;
  localparam int  GAIN_W    = 6;
  localparam int  SMP_W     = 8;
  localparam int  LOG_W     = 9;
  localparam real LOG_SCALE = 64.0;
  localparam real PI        = 3.14159265358979;

  // -scale*ln(sin) over a quarter cycle; entry 0 is the "zero" code
  function automatic int log_sine_val(input int k, input int n, input int zero, input real scale);
    real x;
    if (k == 0) return zero;
    x = (PI / 2.0) * real'(k) / real'(n - 1);
    return $rtoi(-scale * $ln($sin(x)) + 0.5);
  endfunction

  // -scale*ln(g), g = k/(n-1); entry 0 is the "zero" code
  function automatic int log_gain_val(input int k, input int n, input int zero, input real scale);
    if (k == 0) return zero;
    return $rtoi(-scale * $ln(real'(k) / real'(n - 1)) + 0.5);
  endfunction

  function automatic int exp_val(input int k, input int amp, input real scale);
    return $rtoi(real'(amp) * $exp(-real'(k) / scale) + 0.5);
  endfunction
endpackage

// File: rtl/lgs_delay.sv
module lgs_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < D; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int k = 1; k < D; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q_o = pipe[D-1];
endmodule

// File: rtl/lgs_fold.sv
module lgs_fold #(
  parameter int PH_W  = 8,
  localparam int QTR_W = PH_W - 2
) (
  input  logic [PH_W-1:0] phase_i,
  output logic [QTR_W:0]  idx_o,
  output logic            neg_o
);
  logic [QTR_W-1:0] off;
  logic [QTR_W:0]   full;

  assign off   = phase_i[QTR_W-1:0];
  assign full  = (QTR_W+1)'(1) << QTR_W;
  // odd quarters run backwards; second half is negated
  assign idx_o = phase_i[PH_W-2] ? full - {1'b0, off} : {1'b0, off};
  assign neg_o = phase_i[PH_W-1];
endmodule

// File: rtl/lgs_core.sv
module lgs_core #(
  parameter int  PH_W      = lgs_pkg::PH_W,
  parameter int  GAIN_W    = lgs_pkg::GAIN_W,
  parameter int  SMP_W     = lgs_pkg::SMP_W,
  parameter int  LOG_W     = lgs_pkg::LOG_W,
  parameter real LOG_SCALE = lgs_pkg::LOG_SCALE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [SMP_W-1:0]  smp_o
);
  localparam int QTR_W    = PH_W - 2;
  localparam int LS_N     = (1 << QTR_W) + 1;
  localparam int LG_N     = 1 << GAIN_W;
  localparam int EX_AW    = LOG_W + 1;
  localparam int EX_N     = 1 << EX_AW;
  localparam int LOG_ZERO = (1 << LOG_W) - 1;
  localparam int AMP      = (1 << (SMP_W - 1)) - 1;

  logic [LOG_W-1:0] ls_rom [LS_N];
  logic [LOG_W-1:0] lg_rom [LG_N];
  logic [SMP_W-2:0] ex_rom [EX_N];

  for (genvar k = 0; k < LS_N; k++) begin : g_ls
    localparam int V = lgs_pkg::log_sine_val(k, LS_N, LOG_ZERO, LOG_SCALE);
    assign ls_rom[k] = LOG_W'(V);
  end
  for (genvar k = 0; k < LG_N; k++) begin : g_lg
    localparam int V = lgs_pkg::log_gain_val(k, LG_N, LOG_ZERO, LOG_SCALE);
    assign lg_rom[k] = LOG_W'(V);
  end
  for (genvar k = 0; k < EX_N; k++) begin : g_ex
    localparam int V = lgs_pkg::exp_val(k, AMP, LOG_SCALE);
    assign ex_rom[k] = (SMP_W-1)'(V);
  end

  logic [QTR_W:0]   idx;
  logic             neg;
  logic [LOG_W-1:0] ls_q, lg_q;
  logic             neg_q;
  logic [EX_AW-1:0] sum;
  logic [SMP_W-1:0] mag_ext, smp_d;

  lgs_fold #(.PH_W(PH_W)) u_fold (
    .phase_i(phase_i),
    .idx_o  (idx),
    .neg_o  (neg)
  );

  // stage 1: log lookups
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q  <= '0;
      lg_q  <= '0;
      neg_q <= 1'b0;
    end else begin
      ls_q  <= ls_rom[idx];
      lg_q  <= lg_rom[gain_i];
      neg_q <= neg;
    end
  end

  // stage 2: log add, exp lookup, sign
  assign sum     = {1'b0, ls_q} + {1'b0, lg_q};
  assign mag_ext = {1'b0, ex_rom[sum]};
  assign smp_d   = neg_q ? -mag_ext : mag_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_o <= '0;
    else         smp_o <= smp_d;
  end
endmodule

// File: rtl/log_sine_gain.sv
module log_sine_gain #(
  parameter int PH_W   = lgs_pkg::PH_W,
  parameter int GAIN_W = lgs_pkg::GAIN_W,
  parameter int SMP_W  = lgs_pkg::SMP_W,
  parameter int LOG_W  = lgs_pkg::LOG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              pm_en_i,
  input  logic [PH_W-1:0]   car_phase_i,
  input  logic [GAIN_W-1:0] car_gain_i,
  input  logic [PH_W-1:0]   msg_phase_i,
  input  logic [GAIN_W-1:0] msg_gain_i,
  output logic              valid_o,
  output logic [SMP_W-1:0]  sample_o
);
  localparam int CORE_LAT = 2;
  localparam int LAT      = 2 * CORE_LAT + 1;

  logic [SMP_W-1:0]  msg_smp;
  logic [PH_W-1:0]   car_ph_d;
  logic              pm_d;
  logic [GAIN_W-1:0] cg_d;
  logic [PH_W-1:0]   ph_q;

  lgs_core #(.PH_W(PH_W), .GAIN_W(GAIN_W), .SMP_W(SMP_W), .LOG_W(LOG_W)) u_msg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(msg_phase_i),
    .gain_i (msg_gain_i),
    .smp_o  (msg_smp)
  );

  lgs_delay #(.W(PH_W + 1), .D(CORE_LAT)) u_dly_ph (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pm_en_i, car_phase_i}),
    .q_o   ({pm_d, car_ph_d})
  );

  lgs_delay #(.W(GAIN_W), .D(CORE_LAT + 1)) u_dly_g (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (car_gain_i),
    .q_o   (cg_d)
  );

  lgs_delay #(.W(1), .D(LAT)) u_dly_v (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (valid_i),
    .q_o   (valid_o)
  );

  // full-scale message (127) is just under half a cycle of carrier phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_q <= '0;
    else if (pm_d) ph_q <= car_ph_d + PH_W'($signed(msg_smp));
    else           ph_q <= car_ph_d;
  end

  lgs_core #(.PH_W(PH_W), .GAIN_W(GAIN_W), .SMP_W(SMP_W), .LOG_W(LOG_W)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(ph_q),
    .gain_i (cg_d),
    .smp_o  (sample_o)
  );
endmodule

// File: rtl/lgs_chk.sv
module lgs_chk #(
  parameter int PH_W   = 8,
  parameter int GAIN_W = 6,
  parameter int SMP_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              pm_en_i,
  input logic [PH_W-1:0]   car_phase_i,
  input logic [GAIN_W-1:0] car_gain_i,
  input logic              valid_o,
  input logic [SMP_W-1:0]  sample_o
);
  localparam int LAT = 5;

  logic [2:0] warm_cnt;
  logic       warm;
  logic signed [SMP_W-1:0] s_smp;

  assign s_smp = sample_o;
  assign warm  = (warm_cnt >= 3'(LAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    warm_cnt <= '0;
    else if (!warm) warm_cnt <= warm_cnt + 3'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r9: assert (!valid_o && sample_o == '0)
        else $error("R9 outputs not quiet in reset");
    end
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> valid_o == $past(valid_i, LAT));

  p_zero_gain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && !pm_en_i && car_gain_i == '0, LAT)) |-> sample_o == '0);

  p_zero_cross_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && !pm_en_i && car_phase_i[PH_W-2:0] == '0, LAT)) |-> sample_o == '0);

  p_neg_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && !pm_en_i && car_phase_i[PH_W-1], LAT)) |-> s_smp <= 0);

  p_pos_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && !pm_en_i && !car_phase_i[PH_W-1], LAT)) |-> s_smp >= 0);

  p_no_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o != {1'b1, {(SMP_W-1){1'b0}}});
endmodule

bind log_sine_gain lgs_chk #(.PH_W(PH_W), .GAIN_W(GAIN_W), .SMP_W(SMP_W)) u_lgs_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .pm_en_i    (pm_en_i),
  .car_phase_i(car_phase_i),
  .car_gain_i (car_gain_i),
  .valid_o    (valid_o),
  .sample_o   (sample_o)
);

// File: tb/tb_log_sine_gain.sv
module tb_log_sine_gain;
  localparam real PI_R = 3.14159265358979;
  localparam int  NV   = 16;
  // {pm, car_phase, car_gain, msg_phase, msg_gain}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'd10,  6'd63, 8'd0,   6'd0},
    {1'b0, 8'd37,  6'd63, 8'd0,   6'd0},
    {1'b0, 8'd100, 6'd32, 8'd0,   6'd0},
    {1'b0, 8'd150, 6'd63, 8'd0,   6'd0},
    {1'b0, 8'd200, 6'd17, 8'd0,   6'd0},
    {1'b0, 8'd255, 6'd63, 8'd0,   6'd0},
    {1'b0, 8'd3,   6'd50, 8'd0,   6'd0},
    {1'b0, 8'd64,  6'd1,  8'd0,   6'd0},
    {1'b0, 8'd170, 6'd45, 8'd0,   6'd0},
    {1'b0, 8'd90,  6'd8,  8'd0,   6'd0},
    {1'b1, 8'd20,  6'd63, 8'd40,  6'd30},
    {1'b1, 8'd100, 6'd45, 8'd200, 6'd63},
    {1'b1, 8'd230, 6'd63, 8'd10,  6'd10},
    {1'b1, 8'd0,   6'd20, 8'd128, 6'd50},
    {1'b1, 8'd70,  6'd63, 8'd60,  6'd63},
    {1'b1, 8'd180, 6'd40, 8'd90,  6'd25}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       valid_i = 1'b0;
  logic       pm_en_i = 1'b0;
  logic [7:0] car_phase_i = '0;
  logic [5:0] car_gain_i = '0;
  logic [7:0] msg_phase_i = '0;
  logic [5:0] msg_gain_i = '0;
  logic       valid_o;
  logic [7:0] sample_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  int n_out = 0;
  int res [NV];

  always #2.5 clk_i = ~clk_i;

  log_sine_gain dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pm_en_i(pm_en_i),
    .car_phase_i(car_phase_i), .car_gain_i(car_gain_i),
    .msg_phase_i(msg_phase_i), .msg_gain_i(msg_gain_i),
    .valid_o(valid_o), .sample_o(sample_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real model(input bit pm, input int cp, input int cg, input int mp, input int mg);
    real th;
    th = 2.0 * PI_R * real'(cp) / 256.0;
    if (pm) th = th + PI_R * (real'(mg) / 63.0) * $sin(2.0 * PI_R * real'(mp) / 256.0);
    return 127.0 * (real'(cg) / 63.0) * $sin(th);
  endfunction

  task automatic run_one(input bit pm, input int cp, input int cg, input int mp, input int mg,
                         output int r);
    @(negedge clk_i);
    pm_en_i = pm; car_phase_i = 8'(cp); car_gain_i = 6'(cg);
    msg_phase_i = 8'(mp); msg_gain_i = 6'(mg); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    r = int'($signed(sample_o));
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && valid_o && n_out < NV) begin
        res[n_out] = int'($signed(sample_o));
        n_out++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b, c, lat;
    real e;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 valid in reset", int'(valid_o), 0);
    chk(sample_o == 8'd0, "R9 sample in reset", int'(sample_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // table stream, one set per cycle
    mon_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      pm_en_i = VEC[i][28]; car_phase_i = VEC[i][27:20]; car_gain_i = VEC[i][19:14];
      msg_phase_i = VEC[i][13:6]; msg_gain_i = VEC[i][5:0]; valid_i = 1'b1;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (8) @(negedge clk_i);
    mon_en = 1'b0;
    chk(n_out == NV, "R8 stream count", n_out, NV);
    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i][28], int'(VEC[i][27:20]), int'(VEC[i][19:14]),
                int'(VEC[i][13:6]), int'(VEC[i][5:0]));
      if (VEC[i][28])
        chk((real'(res[i]) - e <= 12.0) && (e - real'(res[i]) <= 12.0), "R7 pm model", res[i], $rtoi(e));
      else
        chk((real'(res[i]) - e <= 3.0) && (e - real'(res[i]) <= 3.0), "R1 sine model", res[i], $rtoi(e));
    end

    // R8 latency of a lone strobe
    @(negedge clk_i);
    car_phase_i = 8'd64; car_gain_i = 6'd63; pm_en_i = 1'b0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    chk(lat == 5, "R8 latency", lat, 5);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 single pulse", int'(valid_o), 0);

    // peaks and zeros
    run_one(0, 64, 63, 0, 0, a);   chk(a == 127, "R2 peak +", a, 127);
    run_one(0, 192, 63, 0, 0, a);  chk(a == -127, "R2 peak -", a, -127);
    run_one(0, 50, 0, 0, 0, a);    chk(a == 0, "R3 zero gain", a, 0);
    run_one(0, 200, 0, 0, 0, a);   chk(a == 0, "R3 zero gain neg half", a, 0);
    run_one(0, 0, 63, 0, 0, a);    chk(a == 0, "R4 phase 0", a, 0);
    run_one(0, 128, 63, 0, 0, a);  chk(a == 0, "R4 phase 128", a, 0);
    run_one(0, 220, 30, 0, 0, a);  chk(a < 0, "R6 second half sign", a, -1);
    run_one(0, 20, 30, 0, 0, a);   chk(a > 0, "R6 first half sign", a, 1);

    // R5 symmetry
    foreach (VEC[i]) begin
      if (i < 3) begin
        int p;
        p = (i == 0) ? 5 : (i == 1) ? 30 : 63;
        run_one(0, p, 40, 0, 0, a);
        run_one(0, 128 - p, 40, 0, 0, b);
        run_one(0, p + 128, 40, 0, 0, c);
        chk(a == b, "R5 mirror", b, a);
        chk(c == -a, "R5 negate", c, -a);
      end
    end

    // R7 exact phase shifts by a full-scale message
    run_one(1, 1, 63, 64, 63, a);  chk(a == 0, "R7 shift to half cycle", a, 0);
    run_one(1, 64, 63, 192, 63, a); chk(a == -127, "R7 shift back", a, -127);

    // R10 zero message gain
    run_one(1, 37, 50, 90, 0, a);  run_one(0, 37, 50, 0, 0, b);
    chk(a == b, "R10 no modulation", a, b);
    run_one(1, 210, 63, 17, 0, a); run_one(0, 210, 63, 0, 0, b);
    chk(a == b, "R10 no modulation neg", a, b);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule